// File: doc/BRIEF.md
# Thread-Interleaved Convolution Cell

This block is one cell of a linear systolic array for 1D convolution. Each sample that arrives on the input pair carries a passing value `x` and a running partial sum `y`. The cell forwards `x` unchanged and sends on `y + x * c`, where `c` is the coefficient held for that sample's stream. Four independent streams share one multiplier and one adder. Accepted samples are assigned to streams in strict round-robin order, so the product of one stream and the sum of that stream never meet in the same cycle. The pipeline therefore takes a new sample every clock and never stalls on the multiply-to-add dependency. Padding samples that a convolution schedule inserts between real samples are simply the traffic of another stream.

Both data edges use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. An output that is offered stays stable until it is taken. The whole pipeline advances as one unit. It holds when the output register is full and the consumer is not ready, and at those times `in_ready` is low. Coefficients are loaded through a plain write port, one stream at a time.

Top module: `conv_thread_cell`

## Requirements
- R1: Each completed sample presents `out_x` equal to its `in_x`, and `out_y` equal to `(in_x * c + in_y) mod 2^DATA_W`. The operands are treated as unsigned, and `c` is the coefficient of the sample's stream.
- R2: The first sample accepted after reset belongs to stream 0. Each further accepted sample belongs to the next stream, in the order 0,1,2,3,0 and so on. `out_tid` carries that stream number, and outputs leave in acceptance order.
- R3: A sample uses the coefficient its stream held before the clock edge that accepts it. A coefficient write on that same edge takes effect only for later samples.
- R4: After reset all coefficients are zero, `out_valid` is low and `in_ready` is high.
- R5: While `out_ready` stays high, the cell accepts a sample on every clock. A sample accepted on edge k is presented after edge k+7.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x`, `out_y` and `out_tid` hold their values.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. When `in_ready` is low, `in_valid` is ignored and no sample enters.
- R8: A cycle without an accepted sample does not use up a stream slot. The next accepted sample still gets the next stream number.
- R9: A write with `coef_we` high sets only the coefficient of stream `coef_tid` to `coef_data`. The other three coefficients keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Cell can take a sample this cycle |
| in_x | input | DATA_W | Passing value, multiplied by the coefficient |
| in_y | input | DATA_W | Incoming partial sum |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | DATA_W | Forwarded passing value |
| out_y | output | DATA_W | Updated partial sum |
| out_tid | output | TID_W | Stream number of the result |
| coef_we | input | 1 | Coefficient write strobe |
| coef_tid | input | TID_W | Stream whose coefficient is written |
| coef_data | input | DATA_W | New coefficient value |

## Verification
The bench aims at a coefficient write that lands on the same edge as a sample of the same stream. A cell that reads the coefficient after the write would return the new product one sample too early. It stalls the output with samples in flight. A design that leaked data past a full output register would change `out_y` while it was held, or would drop a sample. Idle input cycles are placed between samples, because a rotation counter that advanced on every clock would mislabel the streams and mix up their coefficients. Long runs of back-to-back samples check the fixed seven-edge latency and the one-per-clock rate, which fail if any stage waits on the previous product.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
  localparam int unsigned CVC_DATA_W  = 16;
  localparam int unsigned CVC_THREADS = 4;
  localparam int unsigned CVC_MUL_LAT = 3;
  localparam int unsigned CVC_ADD_LAT = 3;
endpackage

// File: rtl/cvc_coef_bank.sv
module cvc_coef_bank #(
  parameter int unsigned W  = 16,
  parameter int unsigned NT = 4,
  parameter int unsigned TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wr_tid,
  input  logic [W-1:0]  wr_data,
  input  logic [TW-1:0] rd_tid,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] c_q [NT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) c_q[i] <= '0;
    end else if (we) begin
      c_q[wr_tid] <= wr_data;
    end
  end

  // read returns the value held before any write on this edge
  assign rd_data = c_q[rd_tid];

  for (genvar g = 0; g < NT; g++) begin : g_iso
    // R9: a write aimed at another stream leaves this entry alone
    a_r9_other_stream_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wr_tid != TW'(g))) |=> $stable(c_q[g]));
  end
endmodule

// File: rtl/cvc_mul_pipe.sv
module cvc_mul_pipe #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 3,
  parameter int unsigned TW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_v,
  input  logic [TW-1:0] in_tid,
  input  logic [W-1:0]  in_x,
  input  logic [W-1:0]  in_c,
  input  logic [W-1:0]  in_y,
  output logic          out_v,
  output logic [TW-1:0] out_tid,
  output logic [W-1:0]  out_x,
  output logic [W-1:0]  out_p,
  output logic [W-1:0]  out_y
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] full_prod;
  assign full_prod = {{W{1'b0}}, in_x} * {{W{1'b0}}, in_c};

  logic          v_q [LAT];
  logic [TW-1:0] t_q [LAT];
  logic [W-1:0]  x_q [LAT];
  logic [W-1:0]  p_q [LAT];
  logic [W-1:0]  y_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        v_q[i] <= 1'b0;
        t_q[i] <= '0;
        x_q[i] <= '0;
        p_q[i] <= '0;
        y_q[i] <= '0;
      end
    end else if (en) begin
      v_q[0] <= in_v;
      t_q[0] <= in_tid;
      x_q[0] <= in_x;
      p_q[0] <= full_prod[W-1:0];
      y_q[0] <= in_y;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        t_q[i] <= t_q[i-1];
        x_q[i] <= x_q[i-1];
        p_q[i] <= p_q[i-1];
        y_q[i] <= y_q[i-1];
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_tid = t_q[LAT-1];
  assign out_x   = x_q[LAT-1];
  assign out_p   = p_q[LAT-1];
  assign out_y   = y_q[LAT-1];
endmodule

// File: rtl/cvc_add_pipe.sv
module cvc_add_pipe #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 3,
  parameter int unsigned TW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_v,
  input  logic [TW-1:0] in_tid,
  input  logic [W-1:0]  in_x,
  input  logic [W-1:0]  in_p,
  input  logic [W-1:0]  in_y,
  output logic          out_v,
  output logic [TW-1:0] out_tid,
  output logic [W-1:0]  out_x,
  output logic [W-1:0]  out_s
);
  logic          v_q [LAT];
  logic [TW-1:0] t_q [LAT];
  logic [W-1:0]  x_q [LAT];
  logic [W-1:0]  s_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        v_q[i] <= 1'b0;
        t_q[i] <= '0;
        x_q[i] <= '0;
        s_q[i] <= '0;
      end
    end else if (en) begin
      v_q[0] <= in_v;
      t_q[0] <= in_tid;
      x_q[0] <= in_x;
      s_q[0] <= in_y + in_p;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        t_q[i] <= t_q[i-1];
        x_q[i] <= x_q[i-1];
        s_q[i] <= s_q[i-1];
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_tid = t_q[LAT-1];
  assign out_x   = x_q[LAT-1];
  assign out_s   = s_q[LAT-1];
endmodule

// File: rtl/conv_thread_cell.sv
module conv_thread_cell
  import cvc_pkg::*;
#(
  parameter int unsigned DATA_W  = CVC_DATA_W,
  parameter int unsigned THREADS = CVC_THREADS,
  parameter int unsigned MUL_LAT = CVC_MUL_LAT,
  parameter int unsigned ADD_LAT = CVC_ADD_LAT,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_x,
  output logic [DATA_W-1:0] out_y,
  output logic [TID_W-1:0]  out_tid,
  input  logic              coef_we,
  input  logic [TID_W-1:0]  coef_tid,
  input  logic [DATA_W-1:0] coef_data
);
  logic advance, accept;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  // stream rotation: moves only when a sample is taken
  logic [TID_W-1:0] tid_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tid_cnt <= '0;
    else if (accept) tid_cnt <= (tid_cnt == TID_W'(THREADS - 1)) ? '0 : tid_cnt + 1'b1;
  end

  logic [DATA_W-1:0] coef_rd;
  cvc_coef_bank #(.W(DATA_W), .NT(THREADS), .TW(TID_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .wr_tid(coef_tid),
    .wr_data(coef_data), .rd_tid(tid_cnt), .rd_data(coef_rd)
  );

  // operand read stage
  logic              rd_v;
  logic [TID_W-1:0]  rd_tid;
  logic [DATA_W-1:0] rd_x, rd_y, rd_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v   <= 1'b0;
      rd_tid <= '0;
      rd_x   <= '0;
      rd_y   <= '0;
      rd_c   <= '0;
    end else if (advance) begin
      rd_v   <= accept;
      rd_tid <= tid_cnt;
      rd_x   <= in_x;
      rd_y   <= in_y;
      rd_c   <= coef_rd;
    end
  end

  logic              m_v;
  logic [TID_W-1:0]  m_tid;
  logic [DATA_W-1:0] m_x, m_p, m_y;
  cvc_mul_pipe #(.W(DATA_W), .LAT(MUL_LAT), .TW(TID_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .in_v(rd_v), .in_tid(rd_tid), .in_x(rd_x), .in_c(rd_c), .in_y(rd_y),
    .out_v(m_v), .out_tid(m_tid), .out_x(m_x), .out_p(m_p), .out_y(m_y)
  );

  logic              a_v;
  logic [TID_W-1:0]  a_tid;
  logic [DATA_W-1:0] a_x, a_s;
  cvc_add_pipe #(.W(DATA_W), .LAT(ADD_LAT), .TW(TID_W)) u_add (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .in_v(m_v), .in_tid(m_tid), .in_x(m_x), .in_p(m_p), .in_y(m_y),
    .out_v(a_v), .out_tid(a_tid), .out_x(a_x), .out_s(a_s)
  );

  // channel write stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tid   <= '0;
      out_x     <= '0;
      out_y     <= '0;
    end else if (advance) begin
      out_valid <= a_v;
      out_tid   <= a_tid;
      out_x     <= a_x;
      out_y     <= a_s;
    end
  end

  // checker state: stream number of the last result taken
  logic [TID_W-1:0] last_tid_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      last_tid_q <= TID_W'(THREADS - 1);
    else if (out_valid && out_ready) last_tid_q <= out_tid;
  end

  // R2: results leave in strict stream rotation
  a_r2_tid_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |->
      out_tid == ((last_tid_q == TID_W'(THREADS - 1)) ? '0 : last_tid_q + 1'b1));

  // R6: an offered result is held while the consumer is not ready
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_tid)));

  // R7: no stream slot is used while the output is blocked
  a_r7_blocked_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(tid_cnt));

  // R8: an idle input cycle does not advance the rotation
  a_r8_bubble_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tid_cnt));
endmodule

// File: tb/tb_conv_thread_cell.sv
module tb_conv_thread_cell;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, coef_we;
  logic [DW-1:0] in_x, in_y, out_x, out_y, coef_data;
  logic [1:0] out_tid, coef_tid;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_thread_cell dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_tid(out_tid), .coef_we(coef_we),
    .coef_tid(coef_tid), .coef_data(coef_data)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] coef_m [NT];
  int tid_m = 0;
  int qx[$], qy[$], qt[$];
  string qtag[$];
  string cur_tag = "R1";
  bit hold_pend = 0;
  logic [DW-1:0] hx, hy;
  logic [1:0] ht;

  function automatic logic [DW-1:0] exp_sum(logic [DW-1:0] x, logic [DW-1:0] c, logic [DW-1:0] y);
    logic [DW-1:0] r;
    r = x * c + y;
    return r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // evaluate the edge about to happen, then move to the next negedge
  task automatic tick();
    #1;
    check("R7", "in_ready rule", int'(in_ready), int'(!out_valid || out_ready));
    if (hold_pend) begin
      check("R6", "held valid", int'(out_valid), 1);
      check("R6", "held x", int'(out_x), int'(hx));
      check("R6", "held y", int'(out_y), int'(hy));
      check("R6", "held tid", int'(out_tid), int'(ht));
      hold_pend = 0;
    end
    if (in_valid && in_ready) begin
      qx.push_back(int'(in_x));
      qy.push_back(int'(exp_sum(in_x, coef_m[tid_m], in_y)));
      qt.push_back(tid_m);
      qtag.push_back(cur_tag);
      tid_m = (tid_m + 1) % NT;
    end
    if (out_valid && out_ready) begin
      if (qx.size() == 0) begin
        check("R2", "unexpected result", 1, 0);
      end else begin
        string t;
        t = qtag.pop_front();
        check(t, "out_x (R1)", int'(out_x), qx.pop_front());
        check(t, "out_y (R1)", int'(out_y), qy.pop_front());
        check(t, "out_tid (R2)", int'(out_tid), qt.pop_front());
      end
    end else if (out_valid) begin
      hold_pend = 1; hx = out_x; hy = out_y; ht = out_tid;
    end
    if (coef_we) coef_m[coef_tid] = coef_data;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    in_valid = 0; coef_we = 0; in_x = '0; in_y = '0; coef_tid = '0; coef_data = '0;
  endtask

  task automatic drain();
    idle_inputs();
    out_ready = 1;
    for (int i = 0; i < 14; i++) tick();
    check("R5", "pipeline drained", qx.size(), 0);
  endtask

  task automatic send(logic [DW-1:0] x, logic [DW-1:0] y);
    in_valid = 1; in_x = x; in_y = y;
    tick();
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NT; i++) coef_m[i] = '0;
    rst_n = 0; out_ready = 1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4: reset state and zero coefficients
    check("R4", "out_valid after reset", int'(out_valid), 0);
    check("R4", "in_ready after reset", int'(in_ready), 1);
    cur_tag = "R4";
    send(16'd77, 16'd1234);
    drain();

    // R5: latency of seven edges
    cur_tag = "R5";
    begin
      int n;
      coef_we = 1; coef_tid = 2'd1; coef_data = 16'd3; tick(); coef_we = 0;
      send(16'd10, 16'd5);
      n = 0;
      while (!out_valid && n < 20) begin tick(); n++; end
      check("R5", "latency", n, 7);
    end
    drain();

    // R5: back-to-back throughput with one sample per clock
    for (int i = 0; i < NT; i++) begin
      coef_we = 1; coef_tid = 2'(i); coef_data = 16'(i * 7 + 2); tick();
    end
    coef_we = 0;
    for (int i = 0; i < 12; i++) begin
      in_valid = 1; in_x = 16'(i * 311 + 9); in_y = 16'(i * 97);
      check("R5", "in_ready each clock", int'(in_ready), 1);
      tick();
    end
    in_valid = 0;
    drain();

    // R3: write and accept of the same stream on one edge
    cur_tag = "R3";
    coef_we = 1; coef_tid = 2'(tid_m); coef_data = 16'd500;
    in_valid = 1; in_x = 16'd4; in_y = 16'd1;
    tick();
    coef_we = 0; in_valid = 0;
    for (int i = 0; i < NT; i++) send(16'd4, 16'd1);
    drain();

    // R8: idle cycles between samples keep the rotation
    cur_tag = "R8";
    for (int i = 0; i < 6; i++) begin
      send(16'(i + 20), 16'(i));
      repeat (i % 3 + 1) tick();
    end
    drain();

    // R9: one stream rewritten, others unchanged
    cur_tag = "R9";
    coef_we = 1; coef_tid = 2'd2; coef_data = 16'hBEEF; tick(); coef_we = 0;
    for (int i = 0; i < 8; i++) send(16'(i + 100), 16'(i * 3));
    drain();

    // R6 / R7: stall with results in flight, input offered while blocked
    cur_tag = "R6";
    for (int i = 0; i < 6; i++) send(16'(i * 1000 + 3), 16'(i + 50));
    out_ready = 0;
    for (int i = 0; i < 12; i++) begin
      in_valid = 1; in_x = 16'hFFFF; in_y = 16'hFFFF;
      tick();
    end
    in_valid = 0;
    drain();

    // random traffic
    cur_tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 10) < 7;
      in_x      = 16'($urandom);
      in_y      = 16'($urandom);
      coef_we   = ($urandom % 20) == 0;
      coef_tid  = 2'($urandom);
      coef_data = 16'($urandom);
      if (i % 500 == 0) begin in_x = 16'hFFFF; in_y = 16'hFFFF; end
      tick();
    end
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule